// File: doc/BRIEF.md
# ADC Conversion Clock Prescaler

This block derives the clock enable that paces an analog-to-digital converter. It runs entirely in one system clock domain. It receives two single-cycle tick strobes, one from the bus clock and one from the external oscillator. A source-select input picks which of the two strobes is counted. A 3-bit ratio input divides the chosen strobe by 1, 2, 4, 8 or 16. The result is a one-cycle enable pulse, `conv_ce_o`, that the converter treats as its conversion clock. Software should choose the source and ratio so that this enable lands near 1 MHz. The external oscillator is a suitable source only when it runs at 1 MHz or faster.

Altering the clock configuration in the middle of a conversion spoils that conversion. For that reason the block also watches a conversion-busy input. When the effective source or ratio changes while busy is high, it raises a sticky error flag, and that flag holds until it is cleared explicitly. Any change of the effective configuration restarts the divider, so the first enable after the change comes one full new period later.

Top module: `adc_clock_prescaler`

## Requirements
- R1: Ratio codes 000, 001, 010 and 011 divide by 1, 2, 4 and 8. In these modes `conv_ce_o` pulses once for every N ticks of the selected strobe.
- R2: Any ratio code with bit 2 set divides by 16, and bits 1:0 are then ignored. Moving between two such codes neither restarts the divider nor sets the error flag, even while busy is high.
- R3: When `src_sel_i` is 1, the bus strobe `bus_tick_i` is counted. When it is 0, the oscillator strobe `osc_tick_i` is counted.
- R4: Reset clears the divider count and both outputs. It also takes the tracked configuration to oscillator source with ratio 000. With those inputs, the first oscillator tick after reset therefore produces an enable straight away.
- R5: `conv_ce_o` is one system cycle wide. It rises in the cycle after the edge that samples the tick completing a period, so divide-by-1 passes every selected tick through with one cycle of latency.
- R6: Ticks on the strobe that is not selected have no effect on the count or on the output.
- R7: A change in the effective source or ratio clears the divider in the cycle in which it is sampled. A tick arriving in that same cycle is discarded, and the next enable follows N further ticks of the new selection.
- R8: A change in the effective configuration sampled while `conv_busy_i` is high sets `cfg_err_o` one cycle later. A change sampled while busy is low does not set it.
- R9: Once set, `cfg_err_o` stays high until `err_clr_i` is sampled high. If a busy-time change and a clear occur in the same cycle, the set wins.
- R10: Reset clears `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick_i | input | 1 | One-cycle tick from the external oscillator |
| bus_tick_i | input | 1 | One-cycle tick from the bus clock |
| src_sel_i | input | 1 | Source select: 1 counts bus ticks, 0 counts oscillator ticks |
| ratio_i | input | 3 | Divide code (000 gives /1, 001 gives /2, 010 gives /4, 011 gives /8, 1xx gives /16) |
| conv_busy_i | input | 1 | High while the converter is mid-conversion |
| err_clr_i | input | 1 | Clears the configuration error flag |
| conv_ce_o | output | 1 | Conversion clock enable pulse |
| cfg_err_o | output | 1 | Sticky flag for a configuration change made during a conversion |

## Verification
A corrupted divider count shows up at the ports as an enable that arrives early or late. The mismatch appears within one divide period of the fault, so at most sixteen selected ticks pass before it is seen. A corrupted copy of the tracked configuration behaves like a phantom change. It causes a spurious restart, which stretches the very next period, and if busy is high it also raises the error flag on the following cycle. The scoreboard compares both outputs on every cycle. Because of that, a one-cycle shift in either output, or a pulse held for two cycles, is reported at the cycle where it occurs.

// File: rtl/adc_ckdiv_pkg.sv
package adc_ckdiv_pkg;

    localparam int CODE_W   = 3;
    localparam int MAX_LOG2 = 4;
    localparam int CNT_W    = MAX_LOG2;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_BUS = 1'b1
    } src_e;

    typedef logic [CODE_W-1:0] ratio_t;
    typedef logic [CNT_W-1:0]  count_t;

    typedef struct packed {
        src_e   src;
        ratio_t ratio;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{src: SRC_OSC, ratio: '0};

    // Collapse every saturating code onto one value so equal divides compare equal
    function automatic ratio_t canon_ratio(ratio_t r);
        if (r[CODE_W-1])
            return ratio_t'(1 << (CODE_W-1));
        return r;
    endfunction

    // Terminal count (N-1) for a code
    function automatic count_t terminal_count(ratio_t r);
        int sh;
        sh = r[CODE_W-1] ? MAX_LOG2 : int'(r[CODE_W-2:0]);
        return count_t'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/adc_tick_select.sv
module adc_tick_select
    import adc_ckdiv_pkg::*;
(
    input  src_e sel_i,
    input  logic osc_tick_i,
    input  logic bus_tick_i,
    output logic tick_o
);
    always_comb begin
        unique case (sel_i)
            SRC_BUS: tick_o = bus_tick_i;
            default: tick_o = osc_tick_i;
        endcase
    end
endmodule

// File: rtl/adc_cfg_watch.sv
module adc_cfg_watch
    import adc_ckdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_i,
    input  logic busy_i,
    input  logic clr_i,
    output logic changed_o,
    output logic err_o
);
    cfg_t cfg_eff;
    cfg_t cfg_q;
    logic err_q;

    always_comb begin
        cfg_eff.src   = cfg_i.src;
        cfg_eff.ratio = canon_ratio(cfg_i.ratio);
    end

    assign changed_o = (cfg_eff != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            err_q <= 1'b0;
        end else begin
            cfg_q <= cfg_eff;
            if (changed_o && busy_i)
                err_q <= 1'b1;
            else if (clr_i)
                err_q <= 1'b0;
        end
    end

    assign err_o = err_q;

    AST_ERR_ON_BUSY_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (changed_o && busy_i) |=> err_o);                                  // R8
    AST_ERR_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(changed_o && busy_i));                      // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_o && !clr_i) |=> err_o);                                      // R9
    AST_CFG_SETTLES: assert property (@(posedge clk) disable iff (rst)
        (changed_o && $stable(cfg_i)) |=> !changed_o);                     // R7
endmodule

// File: rtl/adc_pow2_divider.sv
module adc_pow2_divider
    import adc_ckdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    input  logic   restart_i,
    input  count_t last_i,
    output logic   ce_o
);
    count_t cnt_q;
    logic   ce_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ce_q  <= 1'b0;
        end else if (restart_i) begin
            cnt_q <= '0;
            ce_q  <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q >= last_i) begin
                cnt_q <= '0;
                ce_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + count_t'(1);
                ce_q  <= 1'b0;
            end
        end else begin
            ce_q <= 1'b0;
        end
    end

    assign ce_o = ce_q;

    AST_CE_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        ce_o |-> $past(tick_i && !restart_i));                             // R5
    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ce_o && last_i != '0 && !restart_i) |=> !ce_o);                   // R5
    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (cnt_q == '0 && !ce_o));                             // R7
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !restart_i |-> (cnt_q <= last_i));                                 // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_i) |=> (!ce_o && $stable(cnt_q)));            // R6
endmodule

// File: rtl/adc_clock_prescaler.sv
module adc_clock_prescaler
    import adc_ckdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick_i,
    input  logic              bus_tick_i,
    input  logic              src_sel_i,
    input  logic [CODE_W-1:0] ratio_i,
    input  logic              conv_busy_i,
    input  logic              err_clr_i,
    output logic              conv_ce_o,
    output logic              cfg_err_o
);
    cfg_t   cfg_in;
    logic   sel_tick;
    logic   cfg_changed;
    count_t last_cnt;

    always_comb begin
        cfg_in.src   = src_e'(src_sel_i);
        cfg_in.ratio = ratio_i;
    end

    assign last_cnt = terminal_count(ratio_i);

    adc_tick_select u_sel (
        .sel_i      (cfg_in.src),
        .osc_tick_i (osc_tick_i),
        .bus_tick_i (bus_tick_i),
        .tick_o     (sel_tick)
    );

    adc_cfg_watch u_watch (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg_in),
        .busy_i    (conv_busy_i),
        .clr_i     (err_clr_i),
        .changed_o (cfg_changed),
        .err_o     (cfg_err_o)
    );

    adc_pow2_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (sel_tick),
        .restart_i (cfg_changed),
        .last_i    (last_cnt),
        .ce_o      (conv_ce_o)
    );

    AST_UNSEL_NO_CE: assert property (@(posedge clk) disable iff (rst)
        !sel_tick |=> !conv_ce_o);                                         // R6
    AST_DIV1_PASS: assert property (@(posedge clk) disable iff (rst)
        (ratio_i == 3'b000 && sel_tick && !cfg_changed) |=> conv_ce_o);    // R1
endmodule

// File: tb/sim_adc_clock_prescaler.sv
module sim_adc_clock_prescaler;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       bus_tick = 1'b0;
    logic       src_sel = 1'b0;
    logic [2:0] ratio = 3'b000;
    logic       busy = 1'b0;
    logic       clr = 1'b0;
    logic       ce;
    logic       err;

    always #2.5 clk = ~clk;

    adc_clock_prescaler u0 (
        .clk         (clk),
        .rst         (rst),
        .osc_tick_i  (osc_tick),
        .bus_tick_i  (bus_tick),
        .src_sel_i   (src_sel),
        .ratio_i     (ratio),
        .conv_busy_i (busy),
        .err_clr_i   (clr),
        .conv_ce_o   (ce),
        .cfg_err_o   (err)
    );

    typedef struct {
        int    tgt;
        bit    ce;
        bit    err;
        string req;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // reference state kept from the requirements
    bit       m_src;
    bit [2:0] m_ratio;
    int       m_cnt;
    bit       m_err;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare outputs against queued expectations away from the edge
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].tgt < cyc) void'(sbq.pop_front());
        if (sbq.size() > 0 && sbq[0].tgt == cyc) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (ce !== e.ce || err !== e.err) begin
                n_fail++;
                $display("FAIL %s cycle %0d: ce=%b err=%b expected ce=%b err=%b",
                         e.req, cyc, ce, err, e.ce, e.err);
            end
        end
    end

    task automatic model_reset();
        m_src = 1'b0; m_ratio = 3'b000; m_cnt = 0; m_err = 1'b0;
    endtask

    task automatic step(input bit o, input bit b, input bit s, input bit [2:0] r,
                        input bit bz, input bit cl, input string req);
        bit [2:0] er;
        int       n;
        bit       tk;
        exp_t     e;
        @(posedge clk);
        #1;
        osc_tick = o; bus_tick = b; src_sel = s; ratio = r; busy = bz; clr = cl;
        er = r[2] ? 3'b100 : r;
        n  = r[2] ? 16 : (1 << r[1:0]);
        e.ce = 1'b0;
        if (s != m_src || er != m_ratio) begin
            m_src = s; m_ratio = er; m_cnt = 0;
            if (bz) m_err = 1'b1;
            else if (cl) m_err = 1'b0;
        end else begin
            if (cl) m_err = 1'b0;
            tk = s ? b : o;
            if (tk) begin
                if (m_cnt == n - 1) begin m_cnt = 0; e.ce = 1'b1; end
                else m_cnt++;
            end
        end
        e.tgt = cyc + 1; e.err = m_err; e.req = req;
        sbq.push_back(e);
    endtask

    // ticks on the selected strobe, with the other strobe pulsing in the gaps (R6)
    task automatic burst(input int nt, input bit s, input bit [2:0] r, input string req);
        for (int i = 0; i < nt; i++) begin
            step(s ? 1'b0 : 1'b1, s ? 1'b1 : 1'b0, s, r, 1'b0, 1'b0, req);
            step(s ? 1'b1 : 1'b0, s ? 1'b0 : 1'b1, s, r, 1'b0, 1'b0, "R6");
        end
    endtask

    task automatic reset_dut();
        @(posedge clk);
        #1;
        rst = 1'b1; osc_tick = 0; bus_tick = 0; src_sel = 0; ratio = 0; busy = 0; clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (ce !== 1'b0 || err !== 1'b0) begin
            n_fail++;
            $display("FAIL R4/R10 in reset: ce=%b err=%b expected ce=0 err=0", ce, err);
        end
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        model_reset();
        reset_dut();
        // R4: first oscillator tick after reset passes at divide-by-1
        step(1, 0, 0, 3'b000, 0, 0, "R4");
        step(0, 0, 0, 3'b000, 0, 0, "R4");
        burst(4, 0, 3'b000, "R1");
        step(1, 1, 0, 3'b000, 0, 0, "R5");
        step(1, 0, 0, 3'b000, 0, 0, "R5");
        burst(6, 0, 3'b001, "R1");
        burst(10, 0, 3'b010, "R1");
        burst(18, 0, 3'b011, "R1");
        // R2: saturating codes
        burst(20, 0, 3'b100, "R2");
        burst(5, 0, 3'b100, "R2");
        step(1, 0, 0, 3'b111, 1, 0, "R2");
        burst(14, 0, 3'b111, "R2");
        burst(10, 0, 3'b101, "R2");
        // R3: bus source
        burst(40, 1, 3'b100, "R3");
        burst(8, 1, 3'b001, "R3");
        burst(6, 1, 3'b000, "R3");
        // R7: restart on ratio change with a coincident tick
        burst(3, 1, 3'b010, "R7");
        step(0, 1, 1, 3'b011, 0, 0, "R7");
        burst(10, 1, 3'b011, "R7");
        // R7: restart on source change with a coincident tick
        burst(3, 1, 3'b011, "R7");
        step(1, 1, 0, 3'b011, 0, 0, "R7");
        burst(9, 0, 3'b011, "R7");
        // R8: idle change leaves flag low, busy change sets it
        step(0, 0, 0, 3'b001, 0, 0, "R8");
        step(0, 0, 0, 3'b001, 1, 0, "R8");
        step(0, 0, 0, 3'b010, 1, 0, "R8");
        step(1, 0, 0, 3'b010, 1, 0, "R8");
        // R9: sticky until clear; set beats clear
        burst(4, 0, 3'b010, "R9");
        step(0, 0, 0, 3'b010, 0, 1, "R9");
        step(0, 0, 0, 3'b010, 0, 0, "R9");
        step(0, 0, 0, 3'b011, 1, 1, "R9");
        step(0, 0, 0, 3'b011, 0, 0, "R9");
        step(0, 0, 0, 3'b011, 1, 0, "R9");
        // R10: reset clears the flag
        reset_dut();
        step(0, 0, 0, 3'b000, 0, 0, "R10");
        burst(6, 1, 3'b001, "R3");
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule